// File: doc/BRIEF.md
# Linear CCD Timing Generator

This block derives all clocks that a linear CCD sensor needs from a single master clock. It produces the two complementary shift phases, the per-pixel reset pulse, the transfer-gate pulse that moves a line of charge into the shift register, and two one-cycle strobes that mark when the analog front end should sample the reference level and the signal level of each pixel. A further one-cycle strobe tells a downstream converter that a pixel has been sampled.

A host writes a timing word through a write-enable and a data bus. The word sets the sensor mode (standard or even/odd), the guardband, the transfer width, the reset offset and width, and the two sample positions. A line starts when a sync input is seen high on a clock edge while the block is idle. The timing word that was written before that edge governs the whole line. A line has three parts: a guardband, then the transfer pulse, then a second guardband. After these comes a fixed number of shift periods, given by the `PIXELS` parameter. The block then returns to idle.

Top module: `ccd_timing_gen`

## Requirements
- R1: After reset, and while idle, phi1, rsPulse, trPulse, refStrobe, sigStrobe and pixValid are low and phi2 is high.
- R2: Number the cycles after the accepting sync edge from 0, and let G be the guard field plus 1 and T be the transfer field plus 1. trPulse is high exactly in cycles G to G+T-1. phi1 stays low from cycle 0 to cycle 2G+T-1, so it is low in both guardbands and during the transfer pulse.
- R3: Standard mode (mode bit 0): the shift period is 8 cycles and starts at cycle S=2G+T. At position p in the period (0..7), phi1 is high for p=1..4, so the first phi1 high comes one cycle after the shift phase starts.
- R4: Even/odd mode (mode bit 1): the shift period is 16 cycles, and phi1 is high for positions 1..8.
- R5: phi2 is the complement of phi1 in every cycle.
- R6: Standard mode: let d=(p-5) mod 8, the distance from the falling edge of phi1. rsPulse is high when offset <= d <= offset+widthField. This gives one pulse of widthField+1 cycles per period.
- R7: Even/odd mode: let d=(p-1) mod 8, the distance from the most recent phi1 edge. The same window rule gives one reset pulse after each phi1 edge, so two pulses per period.
- R8: refStrobe is high for one cycle at position (refPoint mod period), and sigStrobe is high for one cycle at position (sigPoint mod period), in every shift period.
- R9: pixValid is high exactly in the cycle after each cycle in which sigStrobe is high.
- R10: After PIXELS shift periods the block returns to the idle levels of R1.
- R11: A timing write does not change the outputs until the next accepted sync. A line runs with the word written before its sync edge.
- R12: Sync and timing writes that arrive during a line do not alter that line.
- R13: Timing word layout, from LSB: sigPoint[3:0], refPoint[7:4], widthField[9:8], offset[11:10], transfer field[13:12], guard field[15:14], mode[16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sync | input | 1 | Line start, sampled on the clock edge while idle |
| cfgWrEn | input | 1 | Loads cfgWrData into the pending timing word |
| cfgWrData | input | 17 | Timing word (layout in R13) |
| phi1 | output | 1 | Shift phase 1 |
| phi2 | output | 1 | Shift phase 2, complement of phi1 |
| rsPulse | output | 1 | Output-node reset pulse |
| trPulse | output | 1 | Transfer-gate pulse |
| refStrobe | output | 1 | Reference-level sample point |
| sigStrobe | output | 1 | Signal-level sample point |
| pixValid | output | 1 | Pixel sampled, one cycle after sigStrobe |

## Verification
Four properties are checked on every cycle: the transfer pulse and phi1 never overlap, phi1 is low in the cycle after the transfer pulse falls, a reset pulse never coincides with the transfer pulse, and each pixel-valid pulse follows a one-cycle signal strobe. The remaining behaviour can only be shown by the bench scenarios. This covers the exact cycle positions of the phases, reset windows and sample strobes in both modes, the line length, and the rule that a new timing word waits for the next accepted sync. The bench checks these by sweeping every guard, transfer, offset and width combination in both modes against a cycle-exact arithmetic model.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;
  // Shift period in standard mode; even/odd mode uses twice this.
  localparam int BASE_PERIOD = 8;
  localparam int PT_W        = $clog2(2 * BASE_PERIOD);
  localparam int DIST_W      = $clog2(BASE_PERIOD);
  localparam int FLD_W       = 2;

  typedef struct packed {
    logic             evenOdd;
    logic [FLD_W-1:0] guardM1;
    logic [FLD_W-1:0] trM1;
    logic [FLD_W-1:0] rsOffs;
    logic [FLD_W-1:0] rsWidM1;
    logic [PT_W-1:0]  refPt;
    logic [PT_W-1:0]  sigPt;
  } ccd_cfg_t;

  localparam int CFG_W = $bits(ccd_cfg_t);

  typedef struct packed {
    logic            loadCfg;
    logic            inTr;
    logic            inShift;
    logic [PT_W-1:0] pc;
  } seq_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TR, ST_POST, ST_SHIFT
  } seq_state_t;
endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_timing_pkg::*;
#(
  parameter int PIXELS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sync,
  input  ccd_cfg_t cfgAct,
  output seq_ctl_t ctl
);
  localparam int PIX_W = (PIXELS > 1) ? $clog2(PIXELS) : 1;

  seq_state_t       state;
  logic [FLD_W-1:0] phCnt;
  logic [PT_W-1:0]  pc;
  logic [PIX_W-1:0] pixCnt;
  logic [PT_W-1:0]  periodLast;

  assign periodLast = cfgAct.evenOdd ? PT_W'(2 * BASE_PERIOD - 1)
                                     : PT_W'(BASE_PERIOD - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phCnt  <= '0;
      pc     <= '0;
      pixCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sync) begin
            state <= ST_PRE;
            phCnt <= '0;
          end
        end
        ST_PRE: begin
          if (phCnt == cfgAct.guardM1) begin
            state <= ST_TR;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_TR: begin
          if (phCnt == cfgAct.trM1) begin
            state <= ST_POST;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_POST: begin
          if (phCnt == cfgAct.guardM1) begin
            state  <= ST_SHIFT;
            pc     <= '0;
            pixCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (pc == periodLast) begin
            pc <= '0;
            if (pixCnt == PIX_W'(PIXELS - 1)) begin
              state <= ST_IDLE;
            end else begin
              pixCnt <= pixCnt + 1'b1;
            end
          end else begin
            pc <= pc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadCfg = (state == ST_IDLE) && sync;
    ctl.inTr    = (state == ST_TR);
    ctl.inShift = (state == ST_SHIFT);
    ctl.pc      = pc;
  end
endmodule

// File: rtl/ccd_wave_dp.sv
module ccd_wave_dp
  import ccd_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  seq_ctl_t         ctl,
  output ccd_cfg_t         cfgAct,
  output logic             phi1,
  output logic             phi2,
  output logic             rsPulse,
  output logic             trPulse,
  output logic             refStrobe,
  output logic             sigStrobe,
  output logic             pixValid
);
  ccd_cfg_t          cfgPend;
  logic [PT_W-1:0]   halfPos;
  logic [PT_W-1:0]   ptMask;
  logic [DIST_W-1:0] rsDist;
  logic [DIST_W:0]   rsLo;
  logic [DIST_W:0]   rsHi;

  // Pending word from the host; it becomes active only when a line is accepted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPend  <= '0;
      cfgAct   <= '0;
      pixValid <= 1'b0;
    end else begin
      if (cfgWrEn)     cfgPend <= ccd_cfg_t'(cfgWrData);
      if (ctl.loadCfg) cfgAct  <= cfgPend;
      pixValid <= sigStrobe;
    end
  end

  assign halfPos = cfgAct.evenOdd ? PT_W'(BASE_PERIOD) : PT_W'(BASE_PERIOD / 2);
  assign ptMask  = cfgAct.evenOdd ? PT_W'(2 * BASE_PERIOD - 1) : PT_W'(BASE_PERIOD - 1);

  // Distance from the phi1 edge that anchors the reset pulse.
  generate
    if (DIST_W < PT_W) begin : g_dist
      logic [PT_W-1:0] fromRise;
      logic [PT_W-1:0] fromFall;
      assign fromRise = ctl.pc - PT_W'(1);
      assign fromFall = ctl.pc - PT_W'(BASE_PERIOD / 2 + 1);
      assign rsDist   = cfgAct.evenOdd ? fromRise[DIST_W-1:0] : fromFall[DIST_W-1:0];
    end else begin : g_dist_eq
      assign rsDist = '0;
    end
  endgenerate

  assign rsLo = (DIST_W + 1)'(cfgAct.rsOffs);
  assign rsHi = (DIST_W + 1)'(cfgAct.rsOffs) + (DIST_W + 1)'(cfgAct.rsWidM1);

  always_comb begin
    phi1      = ctl.inShift && (ctl.pc != '0) && (ctl.pc <= halfPos);
    phi2      = !phi1;
    trPulse   = ctl.inTr;
    rsPulse   = ctl.inShift && ({1'b0, rsDist} >= rsLo) && ({1'b0, rsDist} <= rsHi);
    refStrobe = ctl.inShift && (ctl.pc == (cfgAct.refPt & ptMask));
    sigStrobe = ctl.inShift && (ctl.pc == (cfgAct.sigPt & ptMask));
  end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int PIXELS = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sync,
  input  logic                             cfgWrEn,
  input  logic [ccd_timing_pkg::CFG_W-1:0] cfgWrData,
  output logic                             phi1,
  output logic                             phi2,
  output logic                             rsPulse,
  output logic                             trPulse,
  output logic                             refStrobe,
  output logic                             sigStrobe,
  output logic                             pixValid
);
  ccd_timing_pkg::seq_ctl_t ctl;
  ccd_timing_pkg::ccd_cfg_t cfgAct;

  ccd_seq_ctrl #(.PIXELS(PIXELS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sync   (sync),
    .cfgAct (cfgAct),
    .ctl    (ctl)
  );

  ccd_wave_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ctl       (ctl),
    .cfgAct    (cfgAct),
    .phi1      (phi1),
    .phi2      (phi2),
    .rsPulse   (rsPulse),
    .trPulse   (trPulse),
    .refStrobe (refStrobe),
    .sigStrobe (sigStrobe),
    .pixValid  (pixValid)
  );
endmodule

// File: rtl/ccd_timing_chk.sv
module ccd_timing_chk (
  input logic clk,
  input logic rstN,
  input logic phi1,
  input logic rsPulse,
  input logic trPulse,
  input logic sigStrobe,
  input logic pixValid
);
  // Transfer pulse lies inside the guarded window where phi1 is idle.
  assert_tr_phi_apart_R2: assert property (@(posedge clk) disable iff (!rstN)
    trPulse |-> !phi1);

  // Trailing guardband: phi1 still idle right after the transfer pulse ends.
  assert_post_guard_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trPulse) |-> !phi1);

  // Reset pulses only during shifting, never during transfer.
  assert_rs_not_in_tr_R6: assert property (@(posedge clk) disable iff (!rstN)
    trPulse |-> !rsPulse);

  // Signal strobe lasts one cycle.
  assert_sig_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    sigStrobe |=> !sigStrobe);

  // Pixel valid trails the signal strobe by one cycle.
  assert_pix_follows_sig_R9: assert property (@(posedge clk) disable iff (!rstN)
    sigStrobe |=> pixValid);

  assert_pix_only_after_sig_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixValid) |-> $past(sigStrobe));
endmodule

bind ccd_timing_gen ccd_timing_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phi1      (phi1),
  .rsPulse   (rsPulse),
  .trPulse   (trPulse),
  .sigStrobe (sigStrobe),
  .pixValid  (pixValid)
);

// File: tb/test_ccd_timing_gen.sv
module test_ccd_timing_gen;
  import ccd_timing_pkg::*;

  localparam int NPIX = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sync = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [CFG_W-1:0] cfgWrData = '0;
  logic phi1, phi2, rsPulse, trPulse, refStrobe, sigStrobe, pixValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ccd_timing_gen #(.PIXELS(NPIX)) i_ccd_timing_gen (
    .clk(clk), .rstN(rstN), .sync(sync), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .phi1(phi1), .phi2(phi2), .rsPulse(rsPulse), .trPulse(trPulse),
    .refStrobe(refStrobe), .sigStrobe(sigStrobe), .pixValid(pixValid)
  );

  function automatic int periodOf(ccd_cfg_t c);
    return c.evenOdd ? 16 : 8;
  endfunction

  function automatic int shiftStart(ccd_cfg_t c);
    return 2 * (int'(c.guardM1) + 1) + int'(c.trM1) + 1;
  endfunction

  function automatic int lineLen(ccd_cfg_t c);
    return shiftStart(c) + NPIX * periodOf(c);
  endfunction

  function automatic bit sigAt(ccd_cfg_t c, int i);
    int s, p;
    s = shiftStart(c);
    p = periodOf(c);
    if (i < s || i >= lineLen(c)) return 1'b0;
    return ((i - s) % p) == (int'(c.sigPt) % p);
  endfunction

  // Expected {phi1, phi2, rs, tr, ref, sig, pixValid} for cycle i of a line.
  function automatic logic [6:0] model(ccd_cfg_t c, int i);
    int g, t, s, p, pc, d;
    logic e1, er, et, ef, es;
    g = int'(c.guardM1) + 1;
    t = int'(c.trM1) + 1;
    s = shiftStart(c);
    p = periodOf(c);
    e1 = 1'b0; er = 1'b0; ef = 1'b0; es = 1'b0;
    et = (i >= g) && (i < g + t);
    if (i >= s && i < lineLen(c)) begin
      pc = (i - s) % p;
      e1 = (pc >= 1) && (pc <= p / 2);
      d  = c.evenOdd ? (pc + 7) % 8 : (pc + 3) % 8;
      er = (d >= int'(c.rsOffs)) && (d <= int'(c.rsOffs) + int'(c.rsWidM1));
      ef = pc == (int'(c.refPt) % p);
      es = pc == (int'(c.sigPt) % p);
    end
    return {e1, !e1, er, et, ef, es, (i >= 1) ? sigAt(c, i - 1) : 1'b0};
  endfunction

  task automatic checkVec(logic [6:0] exp, ccd_cfg_t c, int i, string ctx);
    logic [6:0] got, diff;
    string tag;
    got = {phi1, phi2, rsPulse, trPulse, refStrobe, sigStrobe, pixValid};
    total++;
    if (got !== exp) begin
      diff = got ^ exp;
      if (diff[6]) tag = c.evenOdd ? "R4" : "R3";
      else if (diff[5]) tag = "R5";
      else if (diff[4]) tag = c.evenOdd ? "R7" : "R6";
      else if (diff[3]) tag = "R2";
      else if (diff[2] || diff[1]) tag = "R8";
      else tag = "R9";
      if (i >= lineLen(c)) tag = "R10";
      if (ctx != "") tag = ctx;
      bad++;
      $display("FAIL %s cycle=%0d got=%b exp=%b", tag, i, got, exp);
    end
  endtask

  task automatic runLine(ccd_cfg_t c, bit writeIt, bit disturb, ccd_cfg_t dc, string ctx);
    int len;
    if (writeIt) begin
      @(negedge clk);
      cfgWrEn = 1'b1;
      cfgWrData = c;
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    len = lineLen(c);
    for (int i = 0; i <= len + 1; i++) begin
      if (i > 0) @(negedge clk);
      checkVec(model(c, i), c, i, ctx);
      if (disturb && (i == len / 2 || i == 2)) begin
        cfgWrEn = 1'b1;
        cfgWrData = dc;
        sync = 1'b1;
      end else begin
        cfgWrEn = 1'b0;
        sync = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R10 watchdog expired got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ccd_cfg_t c, a, b;
    // R1: idle levels during and after reset
    repeat (2) @(negedge clk);
    checkVec(7'b0100000, c, 1000, "R1");
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checkVec(7'b0100000, c, 1000, "R1");
    end

    // Sweep of mode, guard, transfer, reset offset and width (R2..R10, R13)
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 4; g++)
        for (int t = 0; t < 4; t++)
          for (int o = 0; o < 4; o++)
            for (int w = 0; w < 4; w++) begin
              c.evenOdd = m[0];
              c.guardM1 = g[1:0];
              c.trM1    = t[1:0];
              c.rsOffs  = o[1:0];
              c.rsWidM1 = w[1:0];
              c.refPt   = 4'((g * 5 + o * 3 + w) % 16);
              c.sigPt   = 4'((t * 7 + o + m * 3 + w * 2) % 16);
              runLine(c, 1'b1, 1'b0, c, "");
            end

    // R12: writes and syncs in mid-line leave the running line unchanged
    a = '{evenOdd:1'b0, guardM1:2'd1, trM1:2'd2, rsOffs:2'd1, rsWidM1:2'd1, refPt:4'd2, sigPt:4'd6};
    b = '{evenOdd:1'b1, guardM1:2'd3, trM1:2'd0, rsOffs:2'd2, rsWidM1:2'd3, refPt:4'd11, sigPt:4'd13};
    runLine(a, 1'b1, 1'b1, b, "R12");

    // R11: the word written mid-line governs only the next accepted line
    runLine(b, 1'b0, 1'b0, b, "R11");

    // R11: a write with no sync leaves the idle outputs untouched
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = a;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      checkVec(7'b0100000, a, 1000, "R11");
    end
    runLine(a, 1'b0, 1'b0, a, "R11");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule